// File: doc/BRIEF.md
# Counter Flag Interrupt Aggregator

This block sits beside an eight-channel counter array and folds the flag pulses of every channel into one shared interrupt request. The counters themselves live elsewhere; the block only sees their flag lines. Three of these lines are active-low: carry on overflow, borrow on underflow, and compare when the count equals its preset. The fourth, index, is active-high. Each channel has a control byte whose two-bit trigger field picks which flag function can raise that channel's interrupt. A separate enable byte gates each channel into a pending status byte that the host reads over a byte-wide register bus.

A single state machine owns the interrupt function. Its states are `ST_OFF`, `ST_ARMED` and `ST_RAISED`. Reset enters `ST_OFF`. In `ST_OFF`, a write of 0x04 to the channel-operation register (arm) moves it to `ST_ARMED`. In `ST_ARMED`, a gated event (hit) moves it to `ST_RAISED`, and a write of 0x01 (halt) returns it to `ST_OFF`. In `ST_RAISED`, halt goes to `ST_OFF`, arm goes to `ST_ARMED` (or stays in `ST_RAISED` if a hit arrives in the same cycle), and otherwise the state holds. The interrupt line is high only in `ST_RAISED`, so it stays asserted until the host issues a command. Flag inputs pass through a two-stage synchronizer and an edge detector, so each assertion of a flag produces exactly one event.

Top module: `cei_top`

## Requirements
- R1: After reset, every register reads 0x00 and irq is low. The interrupt function starts disabled, so flag events do nothing until the arm command is written.
- R2: The control byte of channel N is at address N (0x00 to 0x07). Bit 0 is count enable, bit 1 is preset-on-index enable, and bits 4:3 are the trigger function. Bits 2, 5, 6 and 7 read back as 0.
- R3: Trigger function 0 (carry) sets the channel's pending bit on a falling edge of its carry_n line. Borrow, compare and index have no effect.
- R4: Trigger function 1 (compare) sets the pending bit on a falling edge of compare_n only.
- R5: Trigger function 2 (carry or borrow) sets the pending bit on a falling edge of either carry_n or borrow_n. Compare and index have no effect.
- R6: Trigger function 3 (index) sets the pending bit on a rising edge of index_p only.
- R7: The enable byte at 0x12 holds one bit per channel (bit N for channel N). A channel whose enable bit is 0 never sets its pending bit.
- R8: The status byte at 0x10 returns pending bit N for channel N. Writes to 0x10 have no effect.
- R9: irq equals the OR of the pending bits, so a status of zero means irq is low. Once set, irq stays high until a command is written to 0x11.
- R10: Writing 0x04 to 0x11 clears all pending bits and enables the interrupt function. An event that arrives in the same cycle as this write is kept.
- R11: Writing 0x01 to 0x11 clears all pending bits, drops irq and disables the interrupt function. Later flag events set nothing until the next arm command.
- R12: Writing any value other than 0x01 or 0x04 to 0x11 changes neither the pending bits nor irq.
- R13: A flag held in its active level sets the pending bit once, on its assertion edge only. Clearing while the flag is still held does not set the bit again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from addr |
| carry_n | input | 8 | Per-channel carry flag, active low |
| borrow_n | input | 8 | Per-channel borrow flag, active low |
| compare_n | input | 8 | Per-channel compare flag, active low |
| index_p | input | 8 | Per-channel index flag, active high |
| irq | output | 1 | Shared interrupt request, active high |

## Verification
A state machine stuck in or wrongly entering `ST_RAISED` shows up as irq disagreeing with the status byte, on the very next read. A pending bit lost or set by the wrong flag shows up in the status byte three clock edges after the flag edge, which is the synchronizer and edge-detector latency. A clear that leaks or arrives late leaves a nonzero status or a high irq on the cycle after the command write. The vector table crosses every trigger function with every flag kind. Directed cases then target the same-cycle clear-and-event race and flags held active across a clear.

// File: rtl/cei_pkg.sv
package cei_pkg;

    typedef enum logic [1:0] {
        TRIG_CARRY        = 2'd0,
        TRIG_COMPARE      = 2'd1,
        TRIG_CARRY_BORROW = 2'd2,
        TRIG_INDEX        = 2'd3
    } trig_fn_e;

    typedef struct packed {
        trig_fn_e fn;
        logic     preset_idx;
        logic     cnt_en;
    } chan_ctrl_t;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_ARMED  = 2'd1,
        ST_RAISED = 2'd2
    } irq_state_e;

    localparam int unsigned DATA_W = 8;

    localparam logic [4:0] ADR_STATUS = 5'h10;
    localparam logic [4:0] ADR_CHOP   = 5'h11;
    localparam logic [4:0] ADR_ENABLE = 5'h12;

    localparam logic [7:0] CMD_HALT = 8'h01;
    localparam logic [7:0] CMD_ARM  = 8'h04;

endpackage

// File: rtl/cei_edge_sync.sv
module cei_edge_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] pulse
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            last_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign pulse = sync_q & ~last_q;

    // a held level yields a single-cycle pulse only
    assert_one_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse != '0) |=> ((pulse & $past(pulse)) == '0));

endmodule

// File: rtl/cei_irq_fsm.sv
module cei_irq_fsm
    import cei_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic halt,
    input  logic hit,
    output logic fn_on,
    output logic irq
);

    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (arm) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (halt)     state_d = ST_OFF;
                else if (hit) state_d = ST_RAISED;
            end
            ST_RAISED: begin
                if (halt)     state_d = ST_OFF;
                else if (arm) state_d = hit ? ST_RAISED : ST_ARMED;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        fn_on = (state_q != ST_OFF);
        irq   = (state_q == ST_RAISED);
    end

    assert_sticky_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !arm && !halt) |=> irq);

    assert_halt_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!fn_on && !irq));

endmodule

// File: rtl/cei_top.sv
module cei_top
    import cei_pkg::*;
#(
    parameter int unsigned NCH    = 8,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic [NCH-1:0]    carry_n,
    input  logic [NCH-1:0]    borrow_n,
    input  logic [NCH-1:0]    compare_n,
    input  logic [NCH-1:0]    index_p,
    output logic              irq
);

    chan_ctrl_t     ctrl_q [NCH];
    logic [NCH-1:0] en_q;
    logic [NCH-1:0] pend_q;
    logic [NCH-1:0] ev_carry, ev_borrow, ev_cmp, ev_idx;
    logic [NCH-1:0] ev_sel;
    logic [NCH-1:0] set_vec;
    logic           fn_on;
    logic           chop_wr, arm, halt;

    cei_edge_sync #(.W(NCH)) u_sync_carry  (.clk(clk), .rst_n(rst_n), .raw(~carry_n),   .pulse(ev_carry));
    cei_edge_sync #(.W(NCH)) u_sync_borrow (.clk(clk), .rst_n(rst_n), .raw(~borrow_n),  .pulse(ev_borrow));
    cei_edge_sync #(.W(NCH)) u_sync_cmp    (.clk(clk), .rst_n(rst_n), .raw(~compare_n), .pulse(ev_cmp));
    cei_edge_sync #(.W(NCH)) u_sync_idx    (.clk(clk), .rst_n(rst_n), .raw(index_p),    .pulse(ev_idx));

    assign chop_wr = wr_en && (addr == ADDR_W'(ADR_CHOP));
    assign arm     = chop_wr && (wr_data == CMD_ARM);
    assign halt    = chop_wr && (wr_data == CMD_HALT);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl_q[g] <= '{fn: TRIG_CARRY, preset_idx: 1'b0, cnt_en: 1'b0};
            end else if (wr_en && (addr == ADDR_W'(g))) begin
                ctrl_q[g].fn         <= trig_fn_e'(wr_data[4:3]);
                ctrl_q[g].preset_idx <= wr_data[1];
                ctrl_q[g].cnt_en     <= wr_data[0];
            end
        end

        always_comb begin
            unique case (ctrl_q[g].fn)
                TRIG_CARRY:        ev_sel[g] = ev_carry[g];
                TRIG_COMPARE:      ev_sel[g] = ev_cmp[g];
                TRIG_CARRY_BORROW: ev_sel[g] = ev_carry[g] | ev_borrow[g];
                TRIG_INDEX:        ev_sel[g] = ev_idx[g];
                default:           ev_sel[g] = 1'b0;
            endcase
        end
    end

    assign set_vec = ev_sel & en_q & {NCH{fn_on}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            if (wr_en && (addr == ADDR_W'(ADR_ENABLE)))
                en_q <= wr_data[NCH-1:0];
            if (halt)     pend_q <= '0;
            else if (arm) pend_q <= set_vec;
            else          pend_q <= pend_q | set_vec;
        end
    end

    cei_irq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .halt  (halt),
        .hit   (set_vec != '0),
        .fn_on (fn_on),
        .irq   (irq)
    );

    always_comb begin
        rd_data = '0;
        if (addr == ADDR_W'(ADR_STATUS)) begin
            rd_data[NCH-1:0] = pend_q;
        end else if (addr == ADDR_W'(ADR_ENABLE)) begin
            rd_data[NCH-1:0] = en_q;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (addr == ADDR_W'(c))
                    rd_data = {3'b000, ctrl_q[c].fn, 1'b0, ctrl_q[c].preset_idx, ctrl_q[c].cnt_en};
            end
        end
    end

    assert_irq_tracks_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (pend_q != '0));

    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && (set_vec == '0)) |=> (pend_q == '0));

    assert_halt_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (pend_q == '0));

    assert_masked_never_pends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

    assert_other_code_keeps_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (chop_wr && !arm && !halt) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

endmodule

// File: tb/cei_top_tb.sv
module cei_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] carry_n = 8'hFF;
    logic [7:0] borrow_n = 8'hFF;
    logic [7:0] compare_n = 8'hFF;
    logic [7:0] index_p = 8'h00;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cei_top u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .carry_n(carry_n),
        .borrow_n(borrow_n), .compare_n(compare_n), .index_p(index_p),
        .irq(irq)
    );

    // vector: {fn[1:0], flag kind[1:0], expect}; kind 0 carry,1 borrow,2 compare,3 index
    localparam logic [4:0] VEC [16] = '{
        {2'd0, 2'd0, 1'b1}, {2'd0, 2'd1, 1'b0}, {2'd0, 2'd2, 1'b0}, {2'd0, 2'd3, 1'b0},
        {2'd1, 2'd0, 1'b0}, {2'd1, 2'd1, 1'b0}, {2'd1, 2'd2, 1'b1}, {2'd1, 2'd3, 1'b0},
        {2'd2, 2'd0, 1'b1}, {2'd2, 2'd1, 1'b1}, {2'd2, 2'd2, 1'b0}, {2'd2, 2'd3, 1'b0},
        {2'd3, 2'd0, 1'b0}, {2'd3, 2'd1, 1'b0}, {2'd3, 2'd2, 1'b0}, {2'd3, 2'd3, 1'b1}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic drive_flag(input int kind, input int ch, input logic on);
        case (kind)
            0: carry_n[ch]   = ~on;
            1: borrow_n[ch]  = ~on;
            2: compare_n[ch] = ~on;
            default: index_p[ch] = on;
        endcase
    endtask

    task automatic pulse(input int kind, input int ch);
        @(negedge clk);
        drive_flag(kind, ch, 1'b1);
        repeat (4) @(negedge clk);
        drive_flag(kind, ch, 1'b0);
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        reg_read(5'h10, d); check("R1 status", d, 8'h00);
        reg_read(5'h12, d); check("R1 enable", d, 8'h00);
        reg_read(5'h03, d); check("R1 ctrl", d, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        reg_write(5'h12, 8'hFF);
        pulse(0, 0);
        reg_read(5'h10, d); check("R1 disabled ignores events", d, 8'h00);
        check("R1 irq disabled", {7'b0, irq}, 8'h00);

        // R2: control byte readback
        reg_write(5'h05, 8'hFF);
        reg_read(5'h05, d); check("R2 ctrl mask", d, 8'h1B);
        reg_write(5'h05, 8'h12);
        reg_read(5'h05, d); check("R2 ctrl fn2", d, 8'h12);

        // R3 R4 R5 R6: function x flag table
        for (int i = 0; i < 16; i++) begin
            int ch;
            ch = i % 8;
            reg_write(5'h11, 8'h04);
            reg_write(5'(ch), {3'b000, VEC[i][4:3], 3'b001});
            pulse(int'(VEC[i][2:1]), ch);
            reg_read(5'h10, d);
            check($sformatf("R3/R4/R5/R6 fn%0d kind%0d status", VEC[i][4:3], VEC[i][2:1]),
                  d, VEC[i][0] ? 8'(1 << ch) : 8'h00);
            check("R9 irq follows status", {7'b0, irq}, {7'b0, VEC[i][0]});
        end

        // R7: masked channel
        reg_write(5'h11, 8'h04);
        reg_write(5'h12, 8'hFB);
        reg_write(5'h02, 8'h18);
        pulse(3, 2);
        reg_read(5'h10, d); check("R7 masked channel", d, 8'h00);
        check("R7 irq", {7'b0, irq}, 8'h00);
        reg_write(5'h12, 8'hFF);

        // R8: multiple channels, status write ignored
        reg_write(5'h01, 8'h00);
        reg_write(5'h06, 8'h08);
        pulse(0, 1);
        pulse(2, 6);
        reg_read(5'h10, d); check("R8 bit per channel", d, 8'h42);
        reg_write(5'h10, 8'h00);
        reg_read(5'h10, d); check("R8 status write ignored", d, 8'h42);

        // R9: sticky
        repeat (20) @(negedge clk);
        check("R9 irq sticky", {7'b0, irq}, 8'h01);

        // R12: other codes
        reg_write(5'h11, 8'h02);
        reg_read(5'h10, d); check("R12 code 0x02 keeps status", d, 8'h42);
        check("R12 irq kept", {7'b0, irq}, 8'h01);

        // R10: clear, then same-cycle event kept
        reg_write(5'h11, 8'h04);
        reg_read(5'h10, d); check("R10 clear", d, 8'h00);
        check("R10 irq low", {7'b0, irq}, 8'h00);
        reg_write(5'h00, 8'h00);
        @(negedge clk);
        carry_n[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        addr = 5'h11; wr_data = 8'h04; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        reg_read(5'h10, d); check("R10 same-cycle event kept", d, 8'h01);
        check("R10 irq raised", {7'b0, irq}, 8'h01);

        // R13: held flag does not re-set after clear
        repeat (4) @(negedge clk);
        reg_write(5'h11, 8'h04);
        repeat (6) @(negedge clk);
        reg_read(5'h10, d); check("R13 held flag once", d, 8'h00);
        carry_n[0] = 1'b1;
        repeat (4) @(negedge clk);

        // R11: halt
        pulse(0, 0);
        reg_write(5'h11, 8'h01);
        reg_read(5'h10, d); check("R11 halt clears", d, 8'h00);
        check("R11 irq low", {7'b0, irq}, 8'h00);
        pulse(0, 0);
        reg_read(5'h10, d); check("R11 events ignored", d, 8'h00);
        reg_write(5'h11, 8'h04);
        pulse(0, 0);
        reg_read(5'h10, d); check("R11 rearm works", d, 8'h01);

        finish_run();
    end

endmodule